// File: doc/BRIEF.md
# Multi-Width Run-Length Sample Encoder

This block compresses a logic-analyser sample stream on its way to capture memory. Samples arrive one per cycle with a valid strobe. The block is configured for 1 to 4 enabled 8-bit channel groups, so the active word is 8, 16, 24 or 32 bits wide. A sample that differs from the one before it is written as a value word. Repeats of the same sample are not written; they add to a pending count. That count is written later as a count word. The top bit of the active width separates the two kinds of word, so the marker always stays inside the bytes that are sent out.

A count of N stands for N further copies of the word written before it. When the count reaches its ceiling, the block writes a saturated count word and carries on counting. Several count words can therefore follow one another, and the reader adds them up. A run can end on a new value in the same cycle as a pending count is due. For that case the block has two write lanes: lane A is always first in memory order and lane B second. A flush input writes out the pending count before capture stops. While encoding is disabled, samples pass straight through, trimmed to the active width.

Top module: `rle_sample_encoder`

## Requirements
- R1: `width_sel` of 0, 1, 2 or 3 selects an active width of 8, 16, 24 or 32 bits. Every written word has zeros above the active width.
- R2: The marker is bit 7, 15, 23 or 31 of the active width. A value word has it cleared, so channel data in that bit is lost. A count word has it set and carries the count in the bits below it.
- R3: With encoding on, the first valid sample after reset, or after `rle_en` rises, is written on lane A as a value word.
- R4: A valid sample equal to the current value, with the count below its ceiling and no flush, writes nothing and increases the pending count by one.
- R5: A sample that differs while the count is nonzero writes the count word on lane A and the new value word on lane B in the same cycle. With a zero count, the value goes alone on lane A.
- R6: The count ceiling is 2^(width-1)-1. A repeat that arrives at the ceiling writes a count word holding the ceiling, and the pending count becomes 1. The count never wraps to zero.
- R7: `cap_flush` writes a nonzero pending count as a count word in the first free lane and clears it. A flush with a zero count and no sample writes nothing.
- R8: A sample and a flush in the same cycle apply the sample first, then flush the count that results. A saturating repeat with a flush writes the ceiling on lane A and a count of 1 on lane B.
- R9: With `rle_en` low, each valid sample is written on lane A unchanged except for trimming to the active width, with the marker bit left as it is. The run state is cleared.
- R10: Outputs are registered and appear one cycle after the sample. Lane B is written only in a cycle where lane A is written too.
- R11: While reset is held, neither lane is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rle_en | input | 1 | Turns run-length encoding on; when low, samples pass through |
| width_sel | input | 2 | Active width: 0=8, 1=16, 2=24, 3=32 bits |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 32 | Sample word |
| cap_flush | input | 1 | Write out the pending count |
| mem_we_a | output | 1 | Write strobe, lane A (first in memory order) |
| mem_word_a | output | 32 | Word for lane A |
| mem_we_b | output | 1 | Write strobe, lane B (second in memory order) |
| mem_word_b | output | 32 | Word for lane B |

## Verification
Two things can land in the same cycle: a flush and an incoming sample. The case that matters most is a flush on the repeat that hits the count ceiling, because then both a saturated count and the flushed remainder are due at once. The directed part of the bench drives exactly that cycle and expects the ceiling on lane A and a count of 1 on lane B. The width sweeps end some streams with the flush on the last sample and others with the flush one cycle later. The bench decodes every stream back into samples and compares it with the samples it sent.

// File: rtl/rle_enc_pkg.sv
package rle_enc_pkg;

   // what the run tracker decided for the current cycle
   typedef enum logic [2:0] {
      ACT_IDLE,
      ACT_FIRST,
      ACT_EXTEND,
      ACT_SATURATE,
      ACT_BREAK,
      ACT_BYPASS
   } act_e;

endpackage

// File: rtl/rle_width_cfg.sv
module rle_width_cfg #(
   parameter int unsigned GROUP_W = 8,
   parameter int unsigned GROUPS  = 4,
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned DATA_W  = 32
) (
   input  logic [SEL_W-1:0]  width_sel,
   output logic [DATA_W-1:0] act_mask,
   output logic [DATA_W-1:0] flag_bit,
   output logic [DATA_W-1:0] cnt_max
);

   localparam int unsigned LAST_G = GROUPS - 1;

   logic [SEL_W-1:0] top_grp;

   // out-of-range selects clamp to the widest setting
   always_comb begin
      if (int'(width_sel) > int'(LAST_G)) top_grp = SEL_W'(LAST_G);
      else                                top_grp = width_sel;
   end

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assign act_mask[g*GROUP_W +: GROUP_W] =
         (SEL_W'(g) <= top_grp) ? {GROUP_W{1'b1}} : {GROUP_W{1'b0}};
      assign flag_bit[g*GROUP_W +: GROUP_W] =
         {(SEL_W'(g) == top_grp), {(GROUP_W-1){1'b0}}};
   end

   assign cnt_max = flag_bit - DATA_W'(1);

endmodule

// File: rtl/rle_run_state.sv
module rle_run_state
   import rle_enc_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              smp_valid,
   input  logic              smp_flush,
   input  logic [DATA_W-1:0] val,
   input  logic [DATA_W-1:0] cnt_max,
   output act_e              act,
   output logic [DATA_W-1:0] cnt_q,
   output logic [DATA_W-1:0] cnt_tail
);

   logic              started_q;
   logic [DATA_W-1:0] last_q;
   logic [DATA_W-1:0] cnt_mid;
   logic [DATA_W-1:0] cnt_d;

   always_comb begin
      act     = ACT_IDLE;
      cnt_mid = cnt_q;
      if (!enable) begin
         cnt_mid = '0;
         if (smp_valid) act = ACT_BYPASS;
      end else if (smp_valid) begin
         if (!started_q) begin
            act     = ACT_FIRST;
            cnt_mid = '0;
         end else if (val == last_q) begin
            if (cnt_q == cnt_max) begin
               act     = ACT_SATURATE;
               cnt_mid = DATA_W'(1);
            end else begin
               act     = ACT_EXTEND;
               cnt_mid = cnt_q + DATA_W'(1);
            end
         end else begin
            act     = ACT_BREAK;
            cnt_mid = '0;
         end
      end
      cnt_tail = (enable && smp_flush) ? cnt_mid : '0;
      cnt_d    = (enable && smp_flush) ? '0 : cnt_mid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started_q <= 1'b0;
         last_q    <= '0;
         cnt_q     <= '0;
      end else if (!enable) begin
         started_q <= 1'b0;
         cnt_q     <= '0;
      end else begin
         cnt_q <= cnt_d;
         if (smp_valid) begin
            started_q <= 1'b1;
            last_q    <= val;
         end
      end
   end

   // R6: the pending count stays within the ceiling of the active width
   a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n || !enable)
      cnt_q <= cnt_max);

   // R6: an unflushed repeat never leaves the count at zero (no wrap)
   a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && smp_valid && started_q && (val == last_q) && !smp_flush) |=> (cnt_q != '0));

   // R7: a flush leaves nothing pending
   a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && smp_flush) |=> (cnt_q == '0));

endmodule

// File: rtl/rle_lane_pack.sv
module rle_lane_pack
   import rle_enc_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  act_e              act,
   input  logic [DATA_W-1:0] cnt_q,
   input  logic [DATA_W-1:0] cnt_tail,
   input  logic [DATA_W-1:0] val,
   input  logic [DATA_W-1:0] raw,
   input  logic [DATA_W-1:0] flag_bit,
   output logic              we_a,
   output logic              we_b,
   output logic [DATA_W-1:0] word_a,
   output logic [DATA_W-1:0] word_b
);

   always_comb begin
      we_a   = 1'b0;
      we_b   = 1'b0;
      word_a = '0;
      word_b = '0;
      unique case (act)
         ACT_BYPASS: begin
            we_a   = 1'b1;
            word_a = raw;
         end
         ACT_FIRST: begin
            we_a   = 1'b1;
            word_a = val;
         end
         ACT_SATURATE: begin
            we_a   = 1'b1;
            word_a = flag_bit | cnt_q;
         end
         ACT_BREAK: begin
            we_a = 1'b1;
            if (cnt_q != '0) begin
               word_a = flag_bit | cnt_q;
               we_b   = 1'b1;
               word_b = val;
            end else begin
               word_a = val;
            end
         end
         default: ;
      endcase
      // flushed remainder takes the first free lane
      if (cnt_tail != '0) begin
         if (!we_a) begin
            we_a   = 1'b1;
            word_a = flag_bit | cnt_tail;
         end else begin
            we_b   = 1'b1;
            word_b = flag_bit | cnt_tail;
         end
      end
   end

endmodule

// File: rtl/rle_sample_encoder.sv
module rle_sample_encoder
   import rle_enc_pkg::*;
#(
   parameter int unsigned GROUP_W = 8,
   parameter int unsigned GROUPS  = 4,
   localparam int unsigned SEL_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
   localparam int unsigned DATA_W = GROUP_W * GROUPS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rle_en,
   input  logic [SEL_W-1:0]  width_sel,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              cap_flush,
   output logic              mem_we_a,
   output logic [DATA_W-1:0] mem_word_a,
   output logic              mem_we_b,
   output logic [DATA_W-1:0] mem_word_b
);

   initial begin
      assert (GROUP_W >= 2) else $error("GROUP_W must be at least 2");
      assert (GROUPS >= 1)  else $error("GROUPS must be at least 1");
   end

   logic [DATA_W-1:0] act_mask, flag_bit, cnt_max;
   logic [DATA_W-1:0] raw_m, val_m, cnt_q, cnt_tail;
   logic              we_a_d, we_b_d;
   logic [DATA_W-1:0] word_a_d, word_b_d;
   act_e              act;

   rle_width_cfg #(
      .GROUP_W(GROUP_W), .GROUPS(GROUPS), .SEL_W(SEL_W), .DATA_W(DATA_W)
   ) u_cfg (
      .width_sel(width_sel),
      .act_mask (act_mask),
      .flag_bit (flag_bit),
      .cnt_max  (cnt_max)
   );

   assign raw_m = smp_data & act_mask;
   assign val_m = raw_m & ~flag_bit;

   rle_run_state #(.DATA_W(DATA_W)) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (rle_en),
      .smp_valid(smp_valid),
      .smp_flush(cap_flush),
      .val      (val_m),
      .cnt_max  (cnt_max),
      .act      (act),
      .cnt_q    (cnt_q),
      .cnt_tail (cnt_tail)
   );

   rle_lane_pack #(.DATA_W(DATA_W)) u_pack (
      .act     (act),
      .cnt_q   (cnt_q),
      .cnt_tail(cnt_tail),
      .val     (val_m),
      .raw     (raw_m),
      .flag_bit(flag_bit),
      .we_a    (we_a_d),
      .we_b    (we_b_d),
      .word_a  (word_a_d),
      .word_b  (word_b_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_we_a   <= 1'b0;
         mem_we_b   <= 1'b0;
         mem_word_a <= '0;
         mem_word_b <= '0;
      end else begin
         mem_we_a   <= we_a_d;
         mem_we_b   <= we_b_d;
         mem_word_a <= word_a_d;
         mem_word_b <= word_b_d;
      end
   end

   // R10: lane B never written alone
   a_r10_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_b |-> mem_we_a);

   // R1: nothing above the active width
   a_r1_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_a |-> ((mem_word_a & ~$past(act_mask)) == '0));

   // R3: first sample of a run sequence lands as a value word
   a_r3_first_value: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_FIRST) |=> (mem_we_a && ((mem_word_a & $past(flag_bit)) == '0)));

   // R4: a plain repeat writes nothing
   a_r4_repeat_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_EXTEND && !cap_flush) |=> !mem_we_a);

   // R6: a saturating repeat writes the full-scale count
   a_r6_saturated_word: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_SATURATE) |=> (mem_we_a && (mem_word_a == ($past(flag_bit) | $past(cnt_max)))));

endmodule

// File: tb/sim_rle_sample_encoder.sv
module sim_rle_sample_encoder;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        rle_en;
   logic [1:0]  width_sel;
   logic        smp_valid;
   logic [31:0] smp_data;
   logic        cap_flush;
   logic        mem_we_a, mem_we_b;
   logic [31:0] mem_word_a, mem_word_b;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   bit          decode_on = 0;
   logic [31:0] flg = 32'h80;
   logic [31:0] msk = 32'hFF;
   logic [31:0] last_dec = '0;
   logic [31:0] sent[$];
   logic [31:0] got[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   rle_sample_encoder u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .rle_en    (rle_en),
      .width_sel (width_sel),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .cap_flush (cap_flush),
      .mem_we_a  (mem_we_a),
      .mem_word_a(mem_word_a),
      .mem_we_b  (mem_we_b),
      .mem_word_b(mem_word_b)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic decode_word(input logic [31:0] w);
      if ((w & flg) != 0) begin
         for (int i = 0; i < int'(w & (flg - 1)); i++) got.push_back(last_dec);
      end else begin
         got.push_back(w);
         last_dec = w;
      end
   endtask

   // stream decoder: lane A before lane B
   always @(negedge clk) begin
      if (decode_on) begin
         if (mem_we_a) decode_word(mem_word_a);
         if (mem_we_b) decode_word(mem_word_b);
      end
   end

   task automatic step(input logic v, input logic [31:0] d, input logic f);
      smp_valid = v;
      smp_data  = d;
      cap_flush = f;
      @(negedge clk);
   endtask

   task automatic drive_run(input logic [31:0] v, input int unsigned n, input bit flush_last);
      for (int unsigned i = 0; i < n; i++) begin
         sent.push_back(v & msk & ~flg);
         step(1'b1, v, flush_last && (i == n - 1));
      end
   endtask

   task automatic sweep(input int w);
      int unsigned lens[$];
      logic [31:0] mx, prev, v;
      int mism;
      rle_en = 1'b0;
      width_sel = 2'(w);
      step(1'b0, '0, 1'b0);
      msk = (w == 3) ? 32'hFFFF_FFFF : ((32'h1 << (8*(w+1))) - 1);
      flg = 32'h1 << (8*(w+1) - 1);
      mx  = flg - 1;
      sent.delete();
      got.delete();
      rle_en = 1'b1;
      decode_on = 1'b1;
      lens = '{1, 1, 2, 5, 3};
      if (mx < 1000) begin
         lens.push_back(mx); lens.push_back(mx + 1);
         lens.push_back(mx + 2); lens.push_back(3*mx + 4);
      end else if (mx < 40000) begin
         lens.push_back(mx + 1); lens.push_back(2*mx + 3);
      end else begin
         lens.push_back(700); lens.push_back(2500);
      end
      prev = 32'hFFFF_FFFF;
      for (int k = 0; k < lens.size(); k++) begin
         v = (32'h9E37_79B1 * (k + 1)) ^ 32'(w << 3);
         if ((v & msk & ~flg) == prev) v = v ^ 32'h1;
         prev = v & msk & ~flg;
         drive_run(v, lens[k], (k == lens.size() - 1) && (w % 2 == 1));
      end
      if (w % 2 == 0) step(1'b0, '0, 1'b1);
      step(1'b0, '0, 1'b0);
      step(1'b0, '0, 1'b0);
      decode_on = 1'b0;
      // R5 R6 R7 R8: decoded stream length matches samples sent
      check($sformatf("R5 R6 R7 R8 decode length w=%0d", w), got.size(), sent.size());
      mism = -1;
      for (int i = 0; i < sent.size() && i < got.size(); i++)
         if (mism < 0 && got[i] !== sent[i]) mism = i;
      // R2 R4 R5: decoded content matches samples with marker cleared
      if (mism >= 0) check($sformatf("R2 R4 R5 decode content w=%0d idx=%0d", w, mism), got[mism], sent[mism]);
      else check($sformatf("R2 R4 R5 decode content w=%0d", w), 0, 0);
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      rle_en = 1'b1;
      width_sel = 2'd0;
      smp_valid = 1'b0;
      smp_data = '0;
      cap_flush = 1'b0;
      repeat (3) @(negedge clk);
      smp_valid = 1'b1; smp_data = 32'h11; cap_flush = 1'b1;
      @(negedge clk);
      // R11: no writes during reset
      check("R11 reset lane A", {31'b0, mem_we_a}, 32'h0);
      check("R11 reset lane B", {31'b0, mem_we_b}, 32'h0);
      smp_valid = 1'b0; cap_flush = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      // 8-bit directed sequence
      step(1'b1, 32'h1C5, 1'b0);
      check("R3 R10 first value strobe", {31'b0, mem_we_a}, 32'h1);
      check("R1 R2 first value word", mem_word_a, 32'h45);
      check("R10 first lane B idle", {31'b0, mem_we_b}, 32'h0);
      for (int i = 0; i < 3; i++) begin
         step(1'b1, 32'h45, 1'b0);
         check("R4 repeat silent", {31'b0, mem_we_a}, 32'h0);
      end
      step(1'b1, 32'h46, 1'b0);
      check("R5 break count lane A", mem_word_a, 32'h83);
      check("R5 break value lane B", {31'b0, mem_we_b} << 8 | mem_word_b, 32'h146);
      step(1'b0, '0, 1'b1);
      check("R7 empty flush silent", {31'b0, mem_we_a}, 32'h0);
      for (int i = 0; i < 127; i++) step(1'b1, 32'h46, 1'b0);
      check("R4 no write up to ceiling", {31'b0, mem_we_a}, 32'h0);
      step(1'b1, 32'h46, 1'b1);
      check("R8 saturate+flush lane A", mem_word_a, 32'hFF);
      check("R8 saturate+flush lane B", {31'b0, mem_we_b} << 8 | mem_word_b, 32'h181);
      step(1'b1, 32'h46, 1'b0);
      step(1'b1, 32'h46, 1'b0);
      step(1'b0, '0, 1'b1);
      check("R7 flush count lane A", mem_word_a, 32'h82);
      check("R7 flush lane B idle", {31'b0, mem_we_b}, 32'h0);
      for (int i = 0; i < 127; i++) step(1'b1, 32'h46, 1'b0);
      step(1'b1, 32'h46, 1'b0);
      check("R6 saturated word", {31'b0, mem_we_a} << 8 | mem_word_a, 32'h1FF);
      check("R6 saturated lane B idle", {31'b0, mem_we_b}, 32'h0);
      step(1'b0, '0, 1'b1);
      check("R6 count resumes at one", mem_word_a, 32'h81);

      // bypass
      rle_en = 1'b0;
      step(1'b1, 32'h1A5, 1'b0);
      check("R9 bypass keeps marker bit", {31'b0, mem_we_a} << 8 | mem_word_a, 32'h1A5);
      width_sel = 2'd1;
      step(1'b1, 32'hFFFF_FFFF, 1'b0);
      check("R1 R9 bypass trimmed to 16", mem_word_a, 32'h0000_FFFF);
      rle_en = 1'b1;
      step(1'b1, 32'h8001, 1'b0);
      check("R3 R2 first after enable", {31'b0, mem_we_a} << 16 | mem_word_a, 32'h1_0001);
      step(1'b0, '0, 1'b0);

      for (int w = 0; w < 4; w++) sweep(w);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule